// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node side of a directory-based cache coherence scheme. For every memory block it owns, it records a coherence state (Uncached, Shared or Exclusive) and a sharer bit vector with one bit per processor. It also holds the memory copy of each block. Caches send it three kinds of request: a read miss, a write miss, and a write-back of a dirty block. For each request it updates the directory entry, writes memory where needed, and sends outgoing messages: data replies, invalidations, fetches and fetch-with-invalidate.

Requests enter through a valid/ready port and are handled one at a time. Outgoing messages leave through a second valid/ready port, one message per handshake. When the current value of a block sits in an owner's cache, the controller sends that owner a fetch. It then waits on a separate fill port for the returned block, writes that block into memory, and only then replies to the requester.

Top module: `dirhome_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty sharer vector and all-zero memory data. `req_ready` is high and `msg_valid` is low.
- R2: A read miss to an Uncached block sends a data reply with the memory value to the requester. The block becomes Shared with only the requester's bit set.
- R3: A write miss to an Uncached block sends a data reply with the memory value to the requester. The block becomes Exclusive with only the requester's bit set.
- R4: A read miss to a Shared block sends a data reply from memory and adds the requester to the sharer vector. The other sharer bits are kept.
- R5: A write miss to a Shared block sends one invalidation to every sharer other than the requester, in ascending processor index order, before any other message. It then sends the data reply, and the block becomes Exclusive owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch to the owner and waits for the fill data. It writes that data into memory and sends it to the requester. The block becomes Shared with both the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-with-invalidate to the owner. The fill data is written into memory and sent to the requester. The block stays Exclusive with the requester as the only owner.
- R8: A write-back to an Exclusive block from its owner writes the carried data into memory and makes the block Uncached with no sharers. No message is sent.
- R9: A write-back from a processor that is not the owner, or to a block that is not Exclusive, is ignored. Directory state and memory stay unchanged.
- R10: While a fetch is outstanding, `req_ready` stays low and no message is offered until the fill data arrives.
- R11: A message offered while `msg_ready` is low stays offered, with unchanged kind, destination, block and data, until it is taken.
- R12: Encodings. The request kind is 0 for a read miss, 1 for a write miss and 2 for a write-back. The message kind is 0 for a data reply, 1 for an invalidation, 2 for a fetch and 3 for a fetch-with-invalidate. The data field is zero on every message that is not a data reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | Request kind (R12) |
| req_src | input | PID_W | Requesting processor |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | Message kind (R12) |
| msg_dst | output | PID_W | Destination processor |
| msg_blk | output | BLK_W | Block index of the message |
| msg_data | output | DATA_W | Reply data |
| fill_valid | input | 1 | Owner's fetched block is present |
| fill_data | input | DATA_W | Owner's fetched block |

## Verification
The bench builds the controller with four processors, eight blocks and 32-bit data. Four processors are enough for a sharer vector where the requester sits between other sharers, so the ascending invalidation order and the skip of the requester can both be seen. Eight blocks allow two blocks in different states to be exercised side by side. The network is sometimes stalled by toggling `msg_ready`, which puts invalidation trains and replies under backpressure. Memory contents after fetches and write-backs are read back through later data replies.

// File: rtl/dirhome_pkg.sv
package dirhome_pkg;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MK_REPLY     = 2'd0,
        MK_INVAL     = 2'd1,
        MK_FETCH     = 2'd2,
        MK_FETCH_INV = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_INV,
        ST_FETCH,
        ST_WAIT,
        ST_REPLY
    } ctl_state_e;

    function automatic logic is_fetch_kind(input logic [1:0] k);
        return (k == MK_FETCH) || (k == MK_FETCH_INV);
    endfunction

endpackage

// File: rtl/dirhome_low_pick.sv
module dirhome_low_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dirhome_entry_table.sv
module dirhome_entry_table
    import dirhome_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int NPROC = 4,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BW-1:0]    rd_idx,
    output dir_state_e       rd_state,
    output logic [NPROC-1:0] rd_sharers,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_idx,
    input  dir_state_e       wr_state,
    input  logic [NPROC-1:0] wr_sharers
);
    dir_state_e       st_mem [NBLK];
    logic [NPROC-1:0] sh_mem [NBLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) begin
                st_mem[i] <= DIR_UNC;
                sh_mem[i] <= '0;
            end
        end else if (wr_en) begin
            st_mem[wr_idx] <= wr_state;
            sh_mem[wr_idx] <= wr_sharers;
        end
    end

    assign rd_state   = st_mem[rd_idx];
    assign rd_sharers = sh_mem[rd_idx];

    // R7: an Exclusive entry always names exactly one owner
    p_excl_one_owner_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_state == DIR_EXC) |-> $onehot(wr_sharers));

    // R8: an Uncached entry is written with an empty sharer vector
    p_unc_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_state == DIR_UNC) |-> (wr_sharers == '0));
endmodule

// File: rtl/dirhome_data_store.sv
module dirhome_data_store #(
    parameter int NBLK   = 8,
    parameter int DATA_W = 32,
    localparam int BW    = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [BW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem [NBLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dirhome_ctrl.sv
module dirhome_ctrl
    import dirhome_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NBLK   = 8,
    parameter int DATA_W = 32,
    localparam int PID_W = $clog2(NPROC),
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [PID_W-1:0]  req_src,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [PID_W-1:0]  msg_dst,
    output logic [BLK_W-1:0]  msg_blk,
    output logic [DATA_W-1:0] msg_data,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    ctl_state_e        st;
    logic [1:0]        rq_kind;
    logic [PID_W-1:0]  rq_src;
    logic [BLK_W-1:0]  rq_blk;
    logic [DATA_W-1:0] rq_data;
    logic [PID_W-1:0]  owner_q;
    logic              fetch_inv_q;
    logic [NPROC-1:0]  inv_mask;
    dir_state_e        nx_state;
    logic [NPROC-1:0]  nx_sh;

    dir_state_e        ent_state;
    logic [NPROC-1:0]  ent_sh;
    logic [DATA_W-1:0] mem_rd;
    logic [NPROC-1:0]  src_bit;
    logic              own_found, inv_found;
    logic [PID_W-1:0]  own_idx, inv_idx;
    logic              wb_take;
    logic              msg_fire;

    logic              tbl_we;
    dir_state_e        tbl_wstate;
    logic [NPROC-1:0]  tbl_wsh;
    logic              dat_we;
    logic [DATA_W-1:0] dat_wdata;

    assign src_bit  = {{(NPROC-1){1'b0}}, 1'b1} << rq_src;
    assign wb_take  = (rq_kind == RQ_WBACK) && (ent_state == DIR_EXC) && ent_sh[rq_src];
    assign msg_fire = msg_valid && msg_ready;

    dirhome_entry_table #(.NBLK(NBLK), .NPROC(NPROC)) u_table (
        .clk(clk), .rst(rst),
        .rd_idx(rq_blk), .rd_state(ent_state), .rd_sharers(ent_sh),
        .wr_en(tbl_we), .wr_idx(rq_blk), .wr_state(tbl_wstate), .wr_sharers(tbl_wsh)
    );

    dirhome_data_store #(.NBLK(NBLK), .DATA_W(DATA_W)) u_data (
        .clk(clk), .rst(rst),
        .rd_idx(rq_blk), .rd_data(mem_rd),
        .wr_en(dat_we), .wr_idx(rq_blk), .wr_data(dat_wdata)
    );

    dirhome_low_pick #(.N(NPROC)) u_owner_pick (
        .mask(ent_sh), .found(own_found), .idx(own_idx)
    );

    dirhome_low_pick #(.N(NPROC)) u_inv_pick (
        .mask(inv_mask), .found(inv_found), .idx(inv_idx)
    );

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            rq_kind     <= '0;
            rq_src      <= '0;
            rq_blk      <= '0;
            rq_data     <= '0;
            owner_q     <= '0;
            fetch_inv_q <= 1'b0;
            inv_mask    <= '0;
            nx_state    <= DIR_UNC;
            nx_sh       <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq_kind <= req_kind;
                        rq_src  <= req_src;
                        rq_blk  <= req_blk;
                        rq_data <= req_data;
                        st      <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    owner_q <= own_idx;
                    unique case (rq_kind)
                        RQ_READ: begin
                            nx_state    <= DIR_SHR;
                            fetch_inv_q <= 1'b0;
                            if (ent_state == DIR_EXC) begin
                                nx_sh <= ent_sh | src_bit;
                                st    <= ST_FETCH;
                            end else begin
                                nx_sh <= (ent_state == DIR_UNC) ? src_bit : (ent_sh | src_bit);
                                st    <= ST_REPLY;
                            end
                        end
                        RQ_WRITE: begin
                            nx_state    <= DIR_EXC;
                            nx_sh       <= src_bit;
                            fetch_inv_q <= 1'b1;
                            if (ent_state == DIR_EXC) begin
                                st <= ST_FETCH;
                            end else if (ent_state == DIR_SHR) begin
                                inv_mask <= ent_sh & ~src_bit;
                                st       <= ST_INV;
                            end else begin
                                st <= ST_REPLY;
                            end
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
                ST_INV: begin
                    if (!inv_found) begin
                        st <= ST_REPLY;
                    end else if (msg_ready) begin
                        inv_mask[inv_idx] <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (msg_ready) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (fill_valid) st <= ST_REPLY;
                end
                ST_REPLY: begin
                    if (msg_ready) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Directory and memory write ports
    always_comb begin
        tbl_we     = 1'b0;
        tbl_wstate = nx_state;
        tbl_wsh    = nx_sh;
        dat_we     = 1'b0;
        dat_wdata  = rq_data;
        if (st == ST_REPLY && msg_ready) begin
            tbl_we = 1'b1;
        end else if (st == ST_DECIDE && wb_take) begin
            tbl_we     = 1'b1;
            tbl_wstate = DIR_UNC;
            tbl_wsh    = '0;
        end
        if (st == ST_DECIDE && wb_take) begin
            dat_we = 1'b1;
        end else if (st == ST_WAIT && fill_valid) begin
            dat_we    = 1'b1;
            dat_wdata = fill_data;
        end
    end

    // Outgoing message
    always_comb begin
        msg_valid = 1'b0;
        msg_kind  = MK_REPLY;
        msg_dst   = rq_src;
        msg_data  = '0;
        unique case (st)
            ST_INV: begin
                msg_valid = inv_found;
                msg_kind  = MK_INVAL;
                msg_dst   = inv_idx;
            end
            ST_FETCH: begin
                msg_valid = 1'b1;
                msg_kind  = fetch_inv_q ? MK_FETCH_INV : MK_FETCH;
                msg_dst   = owner_q;
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                msg_data  = mem_rd;
            end
            default: ;
        endcase
    end

    assign msg_blk   = rq_blk;
    assign req_ready = (st == ST_IDLE);

    // R11: an offered message holds still until taken
    p_msg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind)
            && $stable(msg_dst) && $stable(msg_data) && $stable(msg_blk)));

    // R10: once a fetch leaves, no new request is taken in the next cycle
    p_fetch_holdoff_r10: assert property (@(posedge clk) disable iff (rst)
        (msg_fire && is_fetch_kind(msg_kind)) |=> !req_ready);

    // R5: the requester never receives its own invalidation
    p_inv_not_self_r5: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MK_INVAL) |-> (msg_dst != rq_src));

    // R8: a write-back produces no message in the following cycle
    p_wb_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DECIDE && rq_kind == RQ_WBACK) |=> !msg_valid);

    // R12: non-reply messages carry zero data
    p_zero_data_r12: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind != MK_REPLY) |-> (msg_data == '0));
endmodule

// File: tb/dirhome_ctrl_tb.sv
module dirhome_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NB = 8;
    localparam int DW = 32;
    localparam int PW = $clog2(NP);
    localparam int BW = $clog2(NB);

    typedef struct packed {
        logic [1:0]    k;
        logic [PW-1:0] d;
        logic [BW-1:0] b;
        logic [DW-1:0] v;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_kind = '0;
    logic [PW-1:0] req_src = '0;
    logic [BW-1:0] req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic msg_valid;
    logic msg_ready = 1'b1;
    logic [1:0] msg_kind;
    logic [PW-1:0] msg_dst;
    logic [BW-1:0] msg_blk;
    logic [DW-1:0] msg_data;
    logic fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dirhome_ctrl #(.NPROC(NP), .NBLK(NB), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dst(msg_dst), .msg_blk(msg_blk), .msg_data(msg_data),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    exp_t  exq[$];
    string tagq[$];
    logic  fetch_seen = 1'b0;
    logic  bp_mode = 1'b0;
    logic  bp_tog = 1'b0;
    int    cyc = 0;

    // Reference directory, built from the requirements
    logic [1:0]    m_st  [NB];
    logic [NP-1:0] m_sh  [NB];
    logic [DW-1:0] m_mem [NB];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic int low_bit(input logic [NP-1:0] m);
        for (int i = NP - 1; i >= 0; i--) if (m[i]) low_bit = i;
    endfunction

    task automatic push(input string tag, input logic [1:0] k, input int d,
                        input logic [BW-1:0] b, input logic [DW-1:0] v);
        exq.push_back({k, PW'(d), b, v});
        tagq.push_back(tag);
    endtask

    // Monitor: decides backpressure for the coming edge, then scores any handshake
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
        bp_tog = ~bp_tog;
        msg_ready = bp_mode ? bp_tog : 1'b1;
        if (!rst && msg_valid && msg_ready) begin
            if (exq.size() == 0) begin
                check("R12 unexpected message", {msg_kind, msg_dst}, 64'hFFFF);
            end else begin
                exp_t e;
                string t;
                e = exq.pop_front();
                t = tagq.pop_front();
                check(t, {msg_kind, msg_dst, msg_blk, msg_data}, e);
                if (msg_kind >= 2'd2) fetch_seen = 1'b1;
            end
        end
    end

    // Driver: computes expected messages, issues the request, serves fetches
    task automatic op(input string tag, input logic [1:0] kind, input int src,
                      input int blk, input logic [DW-1:0] wdata, input logic [DW-1:0] fdata);
        logic [NP-1:0] sb;
        logic need_fill;
        sb = NP'(1) << src;
        need_fill = 1'b0;
        case (kind)
            2'd0: begin
                if (m_st[blk] == 2'd2) begin
                    push(tag, 2'd2, low_bit(m_sh[blk]), BW'(blk), '0);
                    m_mem[blk] = fdata;
                    m_sh[blk]  = m_sh[blk] | sb;
                    need_fill  = 1'b1;
                end else begin
                    m_sh[blk] = (m_st[blk] == 2'd0) ? sb : (m_sh[blk] | sb);
                end
                push(tag, 2'd0, src, BW'(blk), m_mem[blk]);
                m_st[blk] = 2'd1;
            end
            2'd1: begin
                if (m_st[blk] == 2'd2) begin
                    push(tag, 2'd3, low_bit(m_sh[blk]), BW'(blk), '0);
                    m_mem[blk] = fdata;
                    need_fill  = 1'b1;
                end else if (m_st[blk] == 2'd1) begin
                    for (int i = 0; i < NP; i++)
                        if (m_sh[blk][i] && i != src) push(tag, 2'd1, i, BW'(blk), '0);
                end
                push(tag, 2'd0, src, BW'(blk), m_mem[blk]);
                m_st[blk] = 2'd2;
                m_sh[blk] = sb;
            end
            default: begin
                if (m_st[blk] == 2'd2 && m_sh[blk][src]) begin
                    m_mem[blk] = wdata;
                    m_st[blk]  = 2'd0;
                    m_sh[blk]  = '0;
                end
            end
        endcase
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_src   = PW'(src);
        req_blk   = BW'(blk);
        req_data  = wdata;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (need_fill) begin
            while (!fetch_seen) @(negedge clk);
            fetch_seen = 1'b0;
            for (int w = 0; w < 3; w++) begin
                @(negedge clk);
                check("R10 hold-off ready", {63'd0, req_ready}, 64'd0);
                check("R10 no message while waiting", {63'd0, msg_valid}, 64'd0);
            end
            fill_valid = 1'b1;
            fill_data  = fdata;
            @(negedge clk);
            fill_valid = 1'b0;
        end
        while (exq.size() != 0 || !req_ready) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_st[i] = 2'd0; m_sh[i] = '0; m_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", {63'd0, req_ready}, 64'd1);
        check("R1 no message after reset", {63'd0, msg_valid}, 64'd0);

        op("R2 read miss uncached", 2'd0, 0, 2, '0, '0);
        op("R4 read miss shared",   2'd0, 1, 2, '0, '0);
        op("R4 read miss shared",   2'd0, 3, 2, '0, '0);
        bp_mode = 1'b1;
        op("R5 write miss shared invalidates", 2'd1, 1, 2, '0, '0);
        op("R6 read miss exclusive fetch", 2'd0, 2, 2, '0, 32'hAAAA0001);
        bp_mode = 1'b0;
        op("R3 write miss uncached", 2'd1, 3, 5, '0, '0);
        op("R7 write miss exclusive fetch-inv", 2'd1, 0, 5, '0, 32'hBBBB0002);
        op("R9 write-back from non-owner", 2'd2, 2, 5, 32'hDEAD0000, '0);
        op("R9 non-owner write-back left owner", 2'd0, 1, 5, '0, 32'hBBBB0003);
        op("R8 owner write-back", 2'd1, 3, 6, '0, '0);
        op("R8 owner write-back", 2'd2, 3, 6, 32'hCCCC0004, '0);
        op("R8 memory after write-back", 2'd0, 1, 6, '0, '0);
        op("R9 write-back to shared block", 2'd2, 1, 2, 32'hDEAD0001, '0);
        op("R9 shared memory unchanged", 2'd0, 0, 2, '0, '0);
        bp_mode = 1'b1;
        op("R5 ascending invalidates skip requester", 2'd1, 2, 2, '0, '0);
        op("R5 sole sharer no invalidate", 2'd1, 1, 6, '0, '0);
        bp_mode = 1'b0;
        op("R1 untouched block reads zero", 2'd0, 3, 7, '0, '0);
        repeat (4) @(negedge clk);
        check("R12 no stray expected messages", 64'(exq.size()), 64'd0);
        finish_run();
    end
endmodule